// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences a small microcontroller into and out of its stop states. When the CPU executes a stop opcode, it raises a one-cycle `stop_req`. If the stop option bit `stop_en` is clear, the request becomes a one-cycle illegal-opcode reset. If the bit is set, the controller latches the two depth-select bits and the timer-keep bit, gates the clocks for one cycle, and then settles in one of three stop depths. In each depth, every power domain is driven to its own on, standby or off level.

The deep depths (stop1 and stop2) are allowed only while the low-voltage reset is disabled. A deep request made while that reset is enabled is served as stop3. Wakeup pins pass through a two-flop synchronizer and are qualified by the latched depth. Leaving stop1 or stop2 always produces a power-on-style reset request. Leaving stop3 through an interrupt source or the periodic timer produces a one-cycle resume pulse. Leaving stop3 through the reset pin produces a power-on-style reset request.

The states are S_RUN, S_GATE, S_STOP1, S_STOP2, S_STOP3, S_POR, S_RESUME and S_ILLOP. The transitions are:
- S_RUN→S_ILLOP on a request with `stop_en`=0.
- S_RUN→S_GATE on a request with `stop_en`=1.
- S_GATE→S_STOPn according to the latched depth.
- S_STOP1/S_STOP2→S_POR on any qualified wake.
- S_STOP3→S_POR on a reset-pin wake.
- S_STOP3→S_RESUME on any other wake.
- S_POR, S_RESUME and S_ILLOP→S_RUN after one cycle.

Top module: `lpstop_ctrl`

## Requirements
- R1: A `stop_req` in S_RUN with `stop_en`=0 raises `illop_rst` for exactly one cycle on the next cycle. No domain output leaves its run level.
- R2: After reset, all domain outputs are 2'b00 (on), `io_ctl`=2'b00 (normal), and `tmr_en`=`clk_en`=1. Domain encoding: 00 on, 01 standby, 10 off. `io_ctl` encoding: 00 normal, 01 hold, 10 reset-state. A `stop_req` with `stop_en`=1 gives one cycle with `clk_en`=0 and the domains still on, then the stop state.
- R3: With PDC=`sel_pdc` and PPDC=`sel_ppdc`, the depth is stop1 for 1/0 and stop2 for 1/1. When PDC is 0 the depth is stop3, whatever PPDC is.
- R4: When `lvr_en`=1 at the request, PDC=1 is served as stop3.
- R5: Stop1: core, RAM and oscillator off; comparator and regulator standby; `io_ctl`=10; `tmr_en`=0; `clk_en`=0.
- R6: Stop2: core and oscillator off; RAM, comparator and regulator standby; `io_ctl`=01; `tmr_en` equals the latched `tmr_keep`; `clk_en`=0.
- R7: Stop3: core and RAM standby; oscillator off; comparator and regulator standby; `io_ctl`=01; `tmr_en` equals the latched `tmr_keep`; `clk_en`=0.
- R8: Changes to `sel_pdc`, `sel_ppdc`, `lvr_en` and `tmr_keep` while the controller is stopped do not change the stop state.
- R9: In stop1, an enabled `wk_irq_raw` or `wk_kbi_raw` wakes on a low level, whatever its polarity bit says. A disabled source never wakes.
- R10: A wake from stop1 or stop2 raises `por_rst` for exactly one cycle. The controller then returns to the run levels.
- R11: In stop3, a wake from `wk_rst_raw` (active low) raises `por_rst`. Any other wake raises `resume` for one cycle with `clk_en`=1.
- R12: In stop2 and stop3, the IRQ and keyboard pins use their polarity bits (1 means active high). `tmr_tick` wakes in those states only when `tmr_keep` was latched as 1. In stop3 it wakes on the cycle after the tick.
- R13: A pin wake shows its reset or resume pulse in the third clock cycle after the pin changes.
- R14: A `stop_req` outside S_RUN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | One-cycle stop opcode strobe |
| stop_en | input | 1 | Stop option bit |
| sel_pdc | input | 1 | Depth select, power-down bit |
| sel_ppdc | input | 1 | Depth select, partial power-down bit |
| lvr_en | input | 1 | Low-voltage reset enable |
| tmr_keep | input | 1 | Keep periodic timer running in stop2/stop3 |
| tmr_tick | input | 1 | Periodic wakeup timer tick |
| wk_rst_raw | input | 1 | Reset pin, active low, asynchronous |
| wk_irq_raw | input | 1 | IRQ pin, asynchronous |
| wk_kbi_raw | input | 1 | Keyboard interrupt pin, asynchronous |
| wk_rst_en | input | 1 | Reset pin wake enable |
| wk_irq_en | input | 1 | IRQ wake enable |
| wk_kbi_en | input | 1 | Keyboard wake enable |
| irq_pol_high | input | 1 | IRQ polarity, 1 = active high |
| kbi_pol_high | input | 1 | Keyboard polarity, 1 = active high |
| pwr_core | output | 2 | CPU, peripheral and flash domain |
| pwr_ram | output | 2 | RAM domain |
| pwr_osc | output | 2 | Oscillator domain |
| pwr_cmp | output | 2 | Comparator domain |
| pwr_vreg | output | 2 | Regulator mode |
| io_ctl | output | 2 | Pin control: normal, hold, reset-state |
| tmr_en | output | 1 | Periodic wakeup timer enable |
| clk_en | output | 1 | Internal clock enable |
| illop_rst | output | 1 | Illegal-opcode reset request |
| por_rst | output | 1 | Power-on-style reset request |
| resume | output | 1 | One-cycle resume pulse |

## Verification
The assertions check on every cycle:
- the one-cycle width of each reset and resume pulse;
- that clocks are off whenever the oscillator is off;
- that the stop1 pin and timer levels go together;
- that a rejected request gives an illegal-opcode reset;
- the low-voltage fallback;
- that no illegal-opcode reset arises outside run.

Only the scenarios can show the rest:
- the full domain map of each depth;
- that the depth selects are frozen while stopped;
- the forced active-low pins in stop1 against configured polarity in stop3;
- the ignored timer tick;
- the three-cycle pin-to-pulse latency, which the scoreboard matches by cycle number.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [2:0] {
        S_RUN,
        S_GATE,
        S_STOP1,
        S_STOP2,
        S_STOP3,
        S_POR,
        S_RESUME,
        S_ILLOP
    } lp_state_e;

    typedef enum logic [1:0] {
        DEPTH_NONE = 2'd0,
        DEPTH_S1   = 2'd1,
        DEPTH_S2   = 2'd2,
        DEPTH_S3   = 2'd3
    } depth_e;

    localparam logic [1:0] PWR_ON   = 2'b00;
    localparam logic [1:0] PWR_STBY = 2'b01;
    localparam logic [1:0] PWR_OFF  = 2'b10;

    localparam logic [1:0] IO_RUN  = 2'b00;
    localparam logic [1:0] IO_HOLD = 2'b01;
    localparam logic [1:0] IO_RST  = 2'b10;

    localparam int WK_RST = 0;
    localparam int WK_IRQ = 1;
    localparam int WK_KBI = 2;
    localparam int WK_NUM = 3;

    typedef struct packed {
        logic [1:0] core;
        logic [1:0] ram;
        logic [1:0] osc;
        logic [1:0] cmp;
        logic [1:0] vreg;
        logic [1:0] io;
        logic       tmr;
        logic       clk;
    } dom_ctl_t;

endpackage

// File: rtl/lpstop_sync.sv
module lpstop_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Each stage is its own flop bank; the first samples the raw pin.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lpstop_depth_dec.sv
module lpstop_depth_dec
    import lpstop_pkg::*;
(
    input  logic   pdc,
    input  logic   ppdc,
    input  logic   lvr_en,
    output depth_e depth
);

    // Deep depths need the low-voltage reset disabled; otherwise fall back to stop3.
    always_comb begin
        if (!pdc || lvr_en) depth = DEPTH_S3;
        else if (ppdc)      depth = DEPTH_S2;
        else                depth = DEPTH_S1;
    end

endmodule

// File: rtl/lpstop_wake_qual.sv
module lpstop_wake_qual
    import lpstop_pkg::*;
(
    input  depth_e            depth,
    input  logic [WK_NUM-1:0] wk_lvl,
    input  logic [WK_NUM-1:0] wk_en,
    input  logic              irq_pol_high,
    input  logic              kbi_pol_high,
    input  logic              tmr_keep,
    input  logic              tmr_tick,
    output logic              wake_hard,
    output logic              wake_soft
);

    logic force_low;
    logic irq_act;
    logic kbi_act;
    logic tmr_act;

    assign force_low = (depth == DEPTH_S1);

    // The deepest depth ignores configured polarity: pins wake on a low level.
    always_comb begin
        if (force_low) begin
            irq_act = ~wk_lvl[WK_IRQ];
            kbi_act = ~wk_lvl[WK_KBI];
        end else begin
            irq_act = irq_pol_high ? wk_lvl[WK_IRQ] : ~wk_lvl[WK_IRQ];
            kbi_act = kbi_pol_high ? wk_lvl[WK_KBI] : ~wk_lvl[WK_KBI];
        end
    end

    assign tmr_act   = !force_low && tmr_keep && tmr_tick;
    assign wake_hard = wk_en[WK_RST] && !wk_lvl[WK_RST];
    assign wake_soft = (wk_en[WK_IRQ] && irq_act) || (wk_en[WK_KBI] && kbi_act) || tmr_act;

endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       stop_en,
    input  logic       sel_pdc,
    input  logic       sel_ppdc,
    input  logic       lvr_en,
    input  logic       tmr_keep,
    input  logic       tmr_tick,
    input  logic       wk_rst_raw,
    input  logic       wk_irq_raw,
    input  logic       wk_kbi_raw,
    input  logic       wk_rst_en,
    input  logic       wk_irq_en,
    input  logic       wk_kbi_en,
    input  logic       irq_pol_high,
    input  logic       kbi_pol_high,
    output logic [1:0] pwr_core,
    output logic [1:0] pwr_ram,
    output logic [1:0] pwr_osc,
    output logic [1:0] pwr_cmp,
    output logic [1:0] pwr_vreg,
    output logic [1:0] io_ctl,
    output logic       tmr_en,
    output logic       clk_en,
    output logic       illop_rst,
    output logic       por_rst,
    output logic       resume
);

    lp_state_e         state_q, state_d;
    depth_e            depth_q, depth_req;
    logic              keep_q;
    logic [WK_NUM-1:0] wk_lvl;
    logic              wake_hard, wake_soft;
    logic              accept;
    dom_ctl_t          ctl;

    lpstop_sync #(
        .WIDTH  (WK_NUM),
        .STAGES (SYNC_STAGES),
        .RST_VAL({WK_NUM{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({wk_kbi_raw, wk_irq_raw, wk_rst_raw}),
        .q    (wk_lvl)
    );

    lpstop_depth_dec u_dec (
        .pdc   (sel_pdc),
        .ppdc  (sel_ppdc),
        .lvr_en(lvr_en),
        .depth (depth_req)
    );

    lpstop_wake_qual u_wake (
        .depth       (depth_q),
        .wk_lvl      (wk_lvl),
        .wk_en       ({wk_kbi_en, wk_irq_en, wk_rst_en}),
        .irq_pol_high(irq_pol_high),
        .kbi_pol_high(kbi_pol_high),
        .tmr_keep    (keep_q),
        .tmr_tick    (tmr_tick),
        .wake_hard   (wake_hard),
        .wake_soft   (wake_soft)
    );

    assign accept = (state_q == S_RUN) && stop_req && stop_en;

    // State register plus the selection latched at an accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            depth_q <= DEPTH_NONE;
            keep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                depth_q <= depth_req;
                keep_q  <= tmr_keep;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN: begin
                if (stop_req) state_d = stop_en ? S_GATE : S_ILLOP;
            end
            S_GATE: begin
                unique case (depth_q)
                    DEPTH_S1: state_d = S_STOP1;
                    DEPTH_S2: state_d = S_STOP2;
                    default:  state_d = S_STOP3;
                endcase
            end
            S_STOP1, S_STOP2: begin
                if (wake_hard || wake_soft) state_d = S_POR;
            end
            S_STOP3: begin
                if (wake_hard)      state_d = S_POR;
                else if (wake_soft) state_d = S_RESUME;
            end
            S_POR, S_RESUME, S_ILLOP: state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    // Output decode: one domain map per state.
    always_comb begin
        ctl       = '{core: PWR_ON, ram: PWR_ON, osc: PWR_ON, cmp: PWR_ON,
                      vreg: PWR_ON, io: IO_RUN, tmr: 1'b1, clk: 1'b1};
        illop_rst = 1'b0;
        por_rst   = 1'b0;
        resume    = 1'b0;
        unique case (state_q)
            S_RUN: ;
            S_GATE: ctl.clk = 1'b0;
            S_STOP1: ctl = '{core: PWR_OFF, ram: PWR_OFF, osc: PWR_OFF, cmp: PWR_STBY,
                             vreg: PWR_STBY, io: IO_RST, tmr: 1'b0, clk: 1'b0};
            S_STOP2: ctl = '{core: PWR_OFF, ram: PWR_STBY, osc: PWR_OFF, cmp: PWR_STBY,
                             vreg: PWR_STBY, io: IO_HOLD, tmr: keep_q, clk: 1'b0};
            S_STOP3: ctl = '{core: PWR_STBY, ram: PWR_STBY, osc: PWR_OFF, cmp: PWR_STBY,
                             vreg: PWR_STBY, io: IO_HOLD, tmr: keep_q, clk: 1'b0};
            S_POR: begin
                ctl.clk = 1'b0;
                por_rst = 1'b1;
            end
            S_RESUME: resume    = 1'b1;
            S_ILLOP:  illop_rst = 1'b1;
            default: ;
        endcase
    end

    assign pwr_core = ctl.core;
    assign pwr_ram  = ctl.ram;
    assign pwr_osc  = ctl.osc;
    assign pwr_cmp  = ctl.cmp;
    assign pwr_vreg = ctl.vreg;
    assign io_ctl   = ctl.io;
    assign tmr_en   = ctl.tmr;
    assign clk_en   = ctl.clk;

endmodule

// File: rtl/lpstop_ctrl_chk.sv
module lpstop_ctrl_chk
    import lpstop_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input lp_state_e  state_q,
    input logic       stop_req,
    input logic       stop_en,
    input logic       lvr_en,
    input logic [1:0] pwr_core,
    input logic [1:0] pwr_ram,
    input logic [1:0] pwr_osc,
    input logic [1:0] io_ctl,
    input logic       tmr_en,
    input logic       clk_en,
    input logic       illop_rst,
    input logic       por_rst,
    input logic       resume
);

    p_illop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && stop_req && !stop_en) |=> illop_rst);

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && stop_req && stop_en) |=> (!clk_en && pwr_core == PWR_ON));

    p_lvr_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && stop_req && stop_en && lvr_en) |=> ##1 (pwr_core == PWR_STBY));

    p_stop1_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ram == PWR_OFF) |-> (io_ctl == IO_RST && !tmr_en && !clk_en));

    p_clk_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_osc == PWR_OFF) |-> !clk_en);

    p_por_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        por_rst |=> (!por_rst && clk_en));

    p_resume_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    p_resume_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> clk_en);

    p_req_ignored_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_RUN) |=> !illop_rst);

endmodule

bind lpstop_ctrl lpstop_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .stop_req (stop_req),
    .stop_en  (stop_en),
    .lvr_en   (lvr_en),
    .pwr_core (pwr_core),
    .pwr_ram  (pwr_ram),
    .pwr_osc  (pwr_osc),
    .io_ctl   (io_ctl),
    .tmr_en   (tmr_en),
    .clk_en   (clk_en),
    .illop_rst(illop_rst),
    .por_rst  (por_rst),
    .resume   (resume)
);

// File: tb/lpstop_ctrl_tb_top.sv
module lpstop_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, stop_en = 0, sel_pdc = 0, sel_ppdc = 0, lvr_en = 0;
    logic tmr_keep = 0, tmr_tick = 0;
    logic wk_rst_raw = 1, wk_irq_raw = 1, wk_kbi_raw = 1;
    logic wk_rst_en = 1, wk_irq_en = 1, wk_kbi_en = 1;
    logic irq_pol_high = 0, kbi_pol_high = 0;
    logic [1:0] pwr_core, pwr_ram, pwr_osc, pwr_cmp, pwr_vreg, io_ctl;
    logic tmr_en, clk_en, illop_rst, por_rst, resume;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // expected-event scoreboard: 0 illop, 1 por, 2 resume
    int    exp_kind[$];
    int    exp_cyc[$];
    string exp_req[$];

    localparam logic [13:0] V_RUN   = {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1};
    localparam logic [13:0] V_GATE  = {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0};
    localparam logic [13:0] V_STOP1 = {2'b10, 2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 1'b0, 1'b0};

    lpstop_ctrl dut_i (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [13:0] v_stop(input bit deep2, input logic keep);
        return deep2 ? {2'b10, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01, keep, 1'b0}
                     : {2'b01, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01, keep, 1'b0};
    endfunction

    function automatic logic [13:0] outs();
        return {pwr_core, pwr_ram, pwr_osc, pwr_cmp, pwr_vreg, io_ctl, tmr_en, clk_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        exp_kind.push_back(kind);
        exp_cyc.push_back(at);
        exp_req.push_back(req);
    endtask

    // monitor: every pulse must match the head of the queue, by kind and cycle
    always @(negedge clk) begin
        if (rst_n && (illop_rst || por_rst || resume)) begin
            automatic int k = illop_rst ? 0 : (por_rst ? 1 : 2);
            if (exp_kind.size() == 0) begin
                chk("R14 unexpected pulse", k, 99);
            end else begin
                automatic int    ek = exp_kind.pop_front();
                automatic int    ec = exp_cyc.pop_front();
                automatic string er = exp_req.pop_front();
                chk({er, " kind"}, k, ek);
                chk({er, " cycle"}, cyc, ec);
            end
        end
    end

    task automatic enter(input logic pdc, input logic ppdc, input logic lvr,
                         input logic keep, input logic [13:0] vexp, input string req);
        @(negedge clk);
        sel_pdc = pdc; sel_ppdc = ppdc; lvr_en = lvr; tmr_keep = keep;
        stop_en = 1; stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        chk("R2 gate cycle", outs(), V_GATE);
        @(negedge clk);
        chk(req, outs(), vexp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        settle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset levels", outs(), V_RUN);

        // R1: rejected request
        stop_en = 0; stop_req = 1;
        expect_ev(0, cyc + 1, "R1");
        @(negedge clk);
        stop_req = 0;
        chk("R1 domains unchanged", outs(), V_RUN);
        settle(2);

        // stop1
        enter(1, 0, 0, 1, V_STOP1, "R3 R5 stop1 map");
        wk_irq_en = 0; wk_irq_raw = 0;
        settle(6);
        chk("R9 disabled irq ignored", outs(), V_STOP1);
        wk_irq_raw = 1;
        stop_req = 1; stop_en = 0;
        @(negedge clk);
        stop_req = 0;
        settle(2);
        chk("R14 request while stopped", outs(), V_STOP1);
        sel_pdc = 0; lvr_en = 1;
        settle(3);
        chk("R8 selects frozen stop1", outs(), V_STOP1);
        wk_irq_en = 1; irq_pol_high = 1;
        settle(3);
        chk("R9 idle-high pin no wake", outs(), V_STOP1);
        wk_irq_raw = 0;
        expect_ev(1, cyc + 3, "R9 R10 R13 stop1 low wake");
        settle(4);
        chk("R10 run after por", outs(), V_RUN);
        wk_irq_raw = 1; irq_pol_high = 0;
        settle(3);

        // stop2
        enter(1, 1, 0, 1, v_stop(1, 1), "R3 R6 stop2 map");
        sel_pdc = 0; sel_ppdc = 0; tmr_keep = 0;
        settle(3);
        chk("R8 selects frozen stop2", outs(), v_stop(1, 1));
        wk_kbi_raw = 0;
        expect_ev(1, cyc + 3, "R10 R13 stop2 kbi wake");
        settle(4);
        chk("R10 run after stop2", outs(), V_RUN);
        wk_kbi_raw = 1;
        settle(3);

        // stop3 with PPDC=1, timer off; irq active high
        irq_pol_high = 1; wk_irq_raw = 0;
        settle(3);
        enter(0, 1, 0, 0, v_stop(0, 0), "R3 R7 stop3 map");
        tmr_tick = 1;
        @(negedge clk);
        tmr_tick = 0;
        settle(2);
        chk("R12 tick ignored without keep", outs(), v_stop(0, 0));
        wk_irq_raw = 1;
        expect_ev(2, cyc + 3, "R11 R12 R13 stop3 high irq");
        @(negedge clk);
        chk("R13 no early wake", outs(), v_stop(0, 0));
        settle(3);
        chk("R11 run after resume", outs(), V_RUN);
        irq_pol_high = 0;
        settle(3);

        // deep request under low-voltage reset -> stop3, timer kept
        enter(1, 0, 1, 1, v_stop(0, 1), "R4 fallback to stop3");
        tmr_tick = 1;
        expect_ev(2, cyc + 1, "R12 timer wake");
        @(negedge clk);
        tmr_tick = 0;
        settle(3);
        chk("R12 run after timer", outs(), V_RUN);

        // stop3 left through reset pin
        enter(0, 0, 0, 0, v_stop(0, 0), "R3 stop3 map pdc0");
        wk_rst_raw = 0;
        expect_ev(1, cyc + 3, "R11 reset pin in stop3");
        settle(4);
        wk_rst_raw = 1;
        settle(3);
        chk("R11 run after pin reset", outs(), V_RUN);

        chk("R10 all events seen", exp_kind.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule